// File: doc/BRIEF.md
# Power-down Entry and Wake Sequencer

This block decides when the chip drops into its low-power state and how it comes back out. Software programs a small control register that holds an arm bit, a wake-delay enable, a wake-interrupt enable and a wake status flag. The chip keeps running until the arm bit is set and the CPU also reports that it has gone to sleep. Only then does the sequencer enter power-down. In power-down it forces off the high-speed crystal enable, the high-speed RC enable, the PLL enable and the system clock enable. The two low-speed source enables pass through untouched.

A wake event is any source in the chip, OR-ed together into one input. It passes through a flip-flop synchroniser and counts only while the block is in power-down. The high-speed sources restart at once. If the wake delay is enabled, the system clock stays held off for a settling window. The length of that window depends on whether the system clock runs from the high-speed crystal or from the high-speed RC oscillator. When the sequence ends, the clock is released, the status flag is set and the arm bit clears itself, so software must arm again before the next sleep.

Top module: `pdwake_seq`

## Requirements
- R1: Power-down is entered only when the arm bit (control bit 0) is 1 and `cpu_sleep` is 1. Either condition alone leaves `sys_clk_en` at 1 and the high-speed enables following their requests.
- R2: In power-down, `hxt_en`, `hirc_en`, `pll_en` and `sys_clk_en` are 0. `lxt_en` and `lirc_en` keep following `lxt_req` and `lirc_req`.
- R3: `wake_evt` is ignored outside power-down: a pulse while running leaves the status flag (control bit 3) at 0 and `sys_clk_en` at 1.
- R4: With the wake delay enabled (control bit 1) and `sclk_is_xtal`=1, `sys_clk_en` returns to 1 exactly XTAL_DLY+3 clock samples after `wake_evt` rises. Two synchroniser stages and one state update are counted in the extra 3.
- R5: With the wake delay enabled and `sclk_is_xtal`=0, `sys_clk_en` returns exactly RC_DLY+3 samples after `wake_evt` rises.
- R6: With the wake delay disabled, `sys_clk_en` returns 3 samples after `wake_evt` rises.
- R7: During the wake delay, `hxt_en`, `hirc_en` and `pll_en` follow their requests again while `sys_clk_en` stays 0.
- R8: Completing a wake clears the arm bit and sets the status flag.
- R9: Writing 1 to control bit 3 clears the status flag. Writing 0 there leaves it unchanged.
- R10: A write-1 to the status flag in the same cycle that a wake completes leaves the flag set.
- R11: `wake_irq` is 1 exactly when the status flag and the interrupt enable (control bit 2) are both 1.
- R12: After reset, `rd_data` is 0, `sys_clk_en` is 1 and `wake_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 4 | Write value: bit0 arm, bit1 delay enable, bit2 interrupt enable, bit3 flag clear (write 1) |
| rd_data | output | 4 | Control register readback, same bit layout, bit3 is the status flag |
| cpu_sleep | input | 1 | CPU reports that it is sleeping |
| wake_evt | input | 1 | OR of all wake sources, asynchronous |
| sclk_is_xtal | input | 1 | 1: system clock runs from the high-speed crystal; 0: from the high-speed RC |
| hxt_req | input | 1 | Requested high-speed crystal enable |
| hirc_req | input | 1 | Requested high-speed RC enable |
| lxt_req | input | 1 | Requested low-speed crystal enable |
| lirc_req | input | 1 | Requested low-speed RC enable |
| pll_req | input | 1 | Requested PLL enable |
| hxt_en | output | 1 | Gated high-speed crystal enable |
| hirc_en | output | 1 | Gated high-speed RC enable |
| lxt_en | output | 1 | Low-speed crystal enable |
| lirc_en | output | 1 | Low-speed RC enable |
| pll_en | output | 1 | Gated PLL enable |
| sys_clk_en | output | 1 | System clock enable |
| wake_irq | output | 1 | Wake interrupt |

## Verification
Two actions can hit the status flag in the same clock edge: the hardware set when a wake completes, and a software write-1 clear. The bench runs a wake with the delay off, so the wake completes on the third edge after `wake_evt` rises. It times a flag-clear write to be sampled on that same edge. The check reads the register back and expects the flag still set. A separate plain clear, with no wake pending, confirms that the clear itself works.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

  localparam int CTL_W   = 4;
  localparam int B_ARM   = 0;
  localparam int B_DLY   = 1;
  localparam int B_IE    = 2;
  localparam int B_FLAG  = 3;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ARMED = 2'd1,
    ST_PDOWN = 2'd2,
    ST_WDLY  = 2'd3
  } pdw_state_e;

  // Length of the clock hold-off window for the current system clock source
  function automatic int unsigned wake_hold_len(input logic from_xtal,
                                                input int unsigned xtal_n,
                                                input int unsigned rc_n);
    return from_xtal ? xtal_n : rc_n;
  endfunction

endpackage

// File: rtl/pdw_sync.sv
module pdw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pdw_ctlreg.sv
module pdw_ctlreg
  import pdw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             hw_arm_clr,
  input  logic             hw_flag_set,
  output logic             arm_q,
  output logic             dly_q,
  output logic             ie_q,
  output logic             flag_q
);
  // hardware clear of the arm bit beats a software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          arm_q <= 1'b0;
    else if (hw_arm_clr) arm_q <= 1'b0;
    else if (wr_en)      arm_q <= wr_data[B_ARM];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= 1'b0;
      ie_q  <= 1'b0;
    end else if (wr_en) begin
      dly_q <= wr_data[B_DLY];
      ie_q  <= wr_data[B_IE];
    end
  end

  // R10: a hardware set beats a write-1 clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       flag_q <= 1'b0;
    else if (hw_flag_set)             flag_q <= 1'b1;
    else if (wr_en && wr_data[B_FLAG]) flag_q <= 1'b0;
  end
endmodule

// File: rtl/pdw_fsm.sv
module pdw_fsm
  import pdw_pkg::*;
#(
  parameter int unsigned XTAL_DLY = 4096,
  parameter int unsigned RC_DLY   = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       cpu_sleep,
  input  logic       wake_s,
  input  logic       dly_en,
  input  logic       sel_xtal,
  output pdw_state_e st_q,
  output logic       wake_done
);
  localparam int unsigned MAX_DLY = (XTAL_DLY > RC_DLY) ? XTAL_DLY : RC_DLY;
  localparam int          CNT_W   = $clog2(MAX_DLY + 1);

  pdw_state_e       st_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;
  logic             wake_hit;
  logic             cnt_zero;

  assign load_val = CNT_W'(wake_hold_len(sel_xtal, XTAL_DLY, RC_DLY) - 1);
  assign wake_hit = (st_q == ST_PDOWN) && wake_s;
  assign cnt_zero = (cnt_q == '0);
  assign wake_done = (wake_hit && !dly_en) || ((st_q == ST_WDLY) && cnt_zero);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:   if (arm) st_d = ST_ARMED;
      ST_ARMED: if (!arm) st_d = ST_RUN;
                else if (cpu_sleep) st_d = ST_PDOWN;
      ST_PDOWN: if (wake_s) st_d = dly_en ? ST_WDLY : ST_RUN;
      ST_WDLY:  if (cnt_zero) st_d = ST_RUN;
      default:  st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (wake_hit && dly_en)         cnt_q <= load_val;
    else if (st_q == ST_WDLY && !cnt_zero) cnt_q <= cnt_q - 1'b1;
  end

  // R1: power-down is only reached from the armed state with sleep active
  a_r1_pd_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PDOWN && $past(st_q) != ST_PDOWN) |-> ($past(arm) && $past(cpu_sleep)));

  // R3: the delay state is only entered out of power-down
  a_r3_wdly_from_pd: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_PDOWN && st_q != ST_WDLY) |=> (st_q != ST_WDLY));

  // R4: the hold-off counter never exceeds the longest window
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WDLY) |-> (int'(cnt_q) < int'(MAX_DLY)));

  // R6: with delay disabled a wake goes straight back to running
  a_r6_no_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_hit && !dly_en) |=> (st_q == ST_RUN));
endmodule

// File: rtl/pdwake_seq.sv
module pdwake_seq
  import pdw_pkg::*;
#(
  parameter int unsigned XTAL_DLY    = 4096,
  parameter int unsigned RC_DLY      = 512,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  output logic [CTL_W-1:0] rd_data,
  input  logic             cpu_sleep,
  input  logic             wake_evt,
  input  logic             sclk_is_xtal,
  input  logic             hxt_req,
  input  logic             hirc_req,
  input  logic             lxt_req,
  input  logic             lirc_req,
  input  logic             pll_req,
  output logic             hxt_en,
  output logic             hirc_en,
  output logic             lxt_en,
  output logic             lirc_en,
  output logic             pll_en,
  output logic             sys_clk_en,
  output logic             wake_irq
);
  logic       wake_s;
  logic       arm_q, dly_q, ie_q, flag_q;
  logic       wake_done;
  logic       hs_gate;
  pdw_state_e st_q;

  pdw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(wake_evt), .q(wake_s)
  );

  pdw_ctlreg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hw_arm_clr(wake_done), .hw_flag_set(wake_done),
    .arm_q(arm_q), .dly_q(dly_q), .ie_q(ie_q), .flag_q(flag_q)
  );

  pdw_fsm #(.XTAL_DLY(XTAL_DLY), .RC_DLY(RC_DLY)) u_fsm (
    .clk(clk), .rst_n(rst_n), .arm(arm_q), .cpu_sleep(cpu_sleep),
    .wake_s(wake_s), .dly_en(dly_q), .sel_xtal(sclk_is_xtal),
    .st_q(st_q), .wake_done(wake_done)
  );

  // high-speed sources come back as soon as the delay window starts
  assign hs_gate    = (st_q == ST_PDOWN);
  assign hxt_en     = hxt_req  && !hs_gate;
  assign hirc_en    = hirc_req && !hs_gate;
  assign pll_en     = pll_req  && !hs_gate;
  assign lxt_en     = lxt_req;
  assign lirc_en    = lirc_req;
  assign sys_clk_en = (st_q == ST_RUN) || (st_q == ST_ARMED);
  assign wake_irq   = flag_q && ie_q;

  always_comb begin
    rd_data         = '0;
    rd_data[B_ARM]  = arm_q;
    rd_data[B_DLY]  = dly_q;
    rd_data[B_IE]   = ie_q;
    rd_data[B_FLAG] = flag_q;
  end

  // R8: a finished wake leaves the arm bit cleared
  a_r8_arm_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> !arm_q);

  // R10: a finished wake always leaves the flag set, whatever the write
  a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> flag_q);

  // R11: a newly raised flag with interrupts enabled drives the interrupt
  a_r11_irq_on_set: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_q) && ie_q) |-> wake_irq);

  // R2: system clock is off whenever the high-speed sources are gated
  a_r2_clk_off_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    hs_gate |-> (!sys_clk_en && !hxt_en && !pll_en));
endmodule

// File: tb/pdwake_seq_bench.sv
`timescale 1ns/1ps
module pdwake_seq_bench;
  localparam int unsigned XTAL_DLY = 4096;
  localparam int unsigned RC_DLY   = 512;
  localparam int SYNC_LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_data = '0;
  logic [3:0] rd_data;
  logic cpu_sleep = 1'b0, wake_evt = 1'b0, sclk_is_xtal = 1'b0;
  logic hxt_req = 1'b0, hirc_req = 1'b0, lxt_req = 1'b0, lirc_req = 1'b0, pll_req = 1'b0;
  logic hxt_en, hirc_en, lxt_en, lirc_en, pll_en, sys_clk_en, wake_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct { string tag; int cycles; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  pdwake_seq #(.XTAL_DLY(XTAL_DLY), .RC_DLY(RC_DLY)) u_pdwake_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cpu_sleep(cpu_sleep), .wake_evt(wake_evt), .sclk_is_xtal(sclk_is_xtal),
    .hxt_req(hxt_req), .hirc_req(hirc_req), .lxt_req(lxt_req), .lirc_req(lirc_req),
    .pll_req(pll_req), .hxt_en(hxt_en), .hirc_en(hirc_en), .lxt_en(lxt_en),
    .lirc_en(lirc_en), .pll_en(pll_en), .sys_clk_en(sys_clk_en), .wake_irq(wake_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // arm, sleep, and confirm the chip is down
  task automatic enter_pd(input logic [3:0] ctl, input string tag);
    wr(ctl);
    cpu_sleep = 1'b1;
    idle(3);
    chk({tag, " sys_clk_en in power-down"}, sys_clk_en, 0);
  endtask

  // driver: push the expected hold-off length, raise the wake, wait for the clock
  task automatic do_wake(input string tag, input int exp_cycles, input bit mid_check);
    exp_q.push_back('{tag, exp_cycles});
    @(negedge clk); wake_evt = 1'b1;
    if (mid_check) begin
      idle(10);
      chk("R7 hxt_en restored in delay", hxt_en, 1);
      chk("R7 pll_en restored in delay", pll_en, 1);
      chk("R7 sys_clk_en held in delay", sys_clk_en, 0);
    end
    while (!sys_clk_en) @(negedge clk);
    idle(2);
    wake_evt = 1'b0;
    cpu_sleep = 1'b0;
    idle(2);
  endtask

  // monitor: measure the wake-to-clock latency and compare against the queue
  initial begin
    forever begin
      @(posedge wake_evt);
      if (exp_q.size() != 0) begin
        int cnt;
        exp_t e;
        cnt = 0;
        do begin
          @(negedge clk);
          cnt++;
        end while (!sys_clk_en);
        e = exp_q.pop_front();
        chk(e.tag, cnt, e.cycles);
      end
    end
  end

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 rd_data after reset", rd_data, 0);
    chk("R12 sys_clk_en after reset", sys_clk_en, 1);
    chk("R12 wake_irq after reset", wake_irq, 0);

    hxt_req = 1; hirc_req = 1; lxt_req = 1; lirc_req = 1; pll_req = 1;

    // R1: sleep without arm, then arm without sleep
    cpu_sleep = 1'b1;
    idle(5);
    chk("R1 sleep alone keeps clock", sys_clk_en, 1);
    chk("R1 sleep alone keeps hxt", hxt_en, 1);
    cpu_sleep = 1'b0;
    wr(4'b0001);
    idle(5);
    chk("R1 arm alone keeps clock", sys_clk_en, 1);

    // R2: gating in power-down
    cpu_sleep = 1'b1;
    idle(3);
    chk("R2 sys_clk_en off", sys_clk_en, 0);
    chk("R2 hxt_en off", hxt_en, 0);
    chk("R2 hirc_en off", hirc_en, 0);
    chk("R2 pll_en off", pll_en, 0);
    chk("R2 lxt_en passes", lxt_en, 1);
    chk("R2 lirc_en passes", lirc_en, 1);
    lxt_req = 1'b0;
    @(negedge clk);
    chk("R2 lxt_en follows request", lxt_en, 0);
    lxt_req = 1'b1;

    // R6: no delay, latency is synchroniser plus state update
    do_wake("R6 no-delay latency", SYNC_LAT, 1'b0);
    chk("R8 arm cleared", rd_data[0], 0);
    chk("R8 flag set", rd_data[3], 1);
    chk("R11 irq off with ie=0", wake_irq, 0);

    // R9 / R11
    wr(4'b0100);
    chk("R9 write 0 keeps flag", rd_data[3], 1);
    chk("R11 irq on", wake_irq, 1);
    wr(4'b1100);
    chk("R9 write 1 clears flag", rd_data[3], 0);
    chk("R11 irq off after clear", wake_irq, 0);

    // R4: crystal window
    sclk_is_xtal = 1'b1;
    enter_pd(4'b0011, "R4");
    do_wake("R4 crystal delay latency", XTAL_DLY + SYNC_LAT, 1'b1);

    // R5: RC window
    sclk_is_xtal = 1'b0;
    enter_pd(4'b1011, "R5");
    do_wake("R5 rc delay latency", RC_DLY + SYNC_LAT, 1'b0);
    chk("R8 arm cleared after delay", rd_data[0], 0);

    // R3: wake while running is ignored
    wr(4'b1000);
    @(negedge clk); wake_evt = 1'b1;
    idle(3);
    wake_evt = 1'b0;
    idle(5);
    chk("R3 flag unchanged by wake in run", rd_data[3], 0);
    chk("R3 clock stays on", sys_clk_en, 1);

    // R10: write-1 clear lands on the edge where the wake completes
    enter_pd(4'b1001, "R10");
    exp_q.push_back('{"R10 no-delay latency", SYNC_LAT});
    @(negedge clk); wake_evt = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_data = 4'b1000;
    @(negedge clk); wr_en = 1'b0;
    chk("R10 flag survives same-cycle clear", rd_data[3], 1);
    chk("R10 clock back", sys_clk_en, 1);
    idle(2);
    wake_evt = 1'b0;
    cpu_sleep = 1'b0;
    idle(4);
    chk("R10 queue drained", exp_q.size(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule